// File: doc/BRIEF.md
# Hamming Chunk ECC Generator and Corrector

This block computes a 24-bit single-error-correcting parity code over one data chunk (512 bytes by default) that arrives one byte per cycle over a valid/ready stream. Each set data bit contributes its 12-bit position, formed from the byte index and the bit index. One 12-bit half of the accumulator folds in that position by XOR. The other half folds in its complement. The packed pair is inverted on output, so a fully erased chunk (every byte 0xFF) produces an all-ones code. When the last byte is taken, the block raises a done flag and also streams the three code bytes out, lowest byte first.

A separate check port takes the code stored with the data and the code just computed from the read data. It classifies their XOR difference as clean, a correctable data error (with byte and bit index), an error in the stored code alone, or uncorrectable. For a correctable data error it repairs the byte in an external buffer by read-modify-write: it reads the byte, inverts the faulty bit and writes it back.

Top module: `hecc_chunk_engine`

## Requirements
- R1: After a full chunk, `code_out` equals the bitwise inverse of {H, L}. H sits in bits 23:12. For every set data bit at position P = {byte index[8:0], bit index[2:0]}, H is the XOR of all such P and L is the XOR of all such ~P (12 bits).
- R2: A chunk of all 0xFF bytes yields `code_out` = 0xFFFFFF. Checking that code against an all-ones stored code gives the clean class.
- R3: `done` rises in the cycle after the CHUNK_BYTES-th byte is accepted (`in_valid` and `in_ready` both high at a clock edge). While `done` is high, `in_ready` is low and offered bytes leave `code_out` unchanged.
- R4: A `start` pulse clears the accumulator, the byte count and `done`. In the next cycle `code_out` is all ones and `done` is low.
- R5: Starting the cycle after `done` rises, `code_bvalid` is high for three consecutive cycles. `code_byte` carries `code_out` bits 7:0, then 15:8, then 23:16.
- R6: A check is accepted when `chk_valid` and `chk_ready` are both high. `res_valid` pulses in the next cycle. The classes are encoded as 0 clean, 1 data error, 2 code error and 3 uncorrectable. A zero difference (stored XOR computed) gives class 0. `res_byte` and `res_bit` are zero except for class 1.
- R7: If the difference's bits 23:12 XOR its bits 11:0 equal 0xFFF and the byte index (difference bits 23:15) is below CHUNK_BYTES, the class is 1. `res_byte` is difference bits 23:15 and `res_bit` is bits 14:12.
- R8: A difference of the R7 form whose byte index is CHUNK_BYTES or more gives class 3.
- R9: A difference with exactly one bit set gives class 2. No buffer read or write follows.
- R10: Any other nonzero difference gives class 3. The buffer is not touched.
- R11: For class 1, `buf_rd_en` with `buf_rd_addr` = byte index is high in the same cycle as `res_valid`. The buffer returns `buf_rd_data` one cycle after the read. One cycle later `buf_wr_en` writes the same address with that byte, the faulty bit inverted. `chk_ready` is low while the repair runs.
- R12: After reset, `in_ready` is high and `done`, `code_bvalid`, `res_valid`, `buf_rd_en` and `buf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clears the accumulator for a new chunk |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Byte can be accepted |
| done | output | 1 | Whole chunk absorbed |
| code_out | output | 24 | Inverted packed parity code |
| code_bvalid | output | 1 | Serial code byte valid |
| code_byte | output | 8 | Serial code byte, lowest first |
| chk_valid | input | 1 | Check request |
| chk_ready | output | 1 | Check port idle |
| chk_stored | input | 24 | Code stored with the data |
| chk_calc | input | 24 | Code computed from read data |
| res_valid | output | 1 | Classification valid |
| res_class | output | 2 | 0 clean, 1 data, 2 code, 3 uncorrectable |
| res_byte | output | 9 | Faulty byte index |
| res_bit | output | 3 | Faulty bit index |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rd_addr | output | 9 | Buffer read address |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the strobe |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | 9 | Buffer write address |
| buf_wr_data | output | 8 | Repaired byte |

## Verification
On every cycle, the assertions check the handshake and timing relations. Ready is low while done is high. A start pulse blanks the code. The serial bytes begin right after done. A result follows every accepted check. A data-class result issues a read at the reported byte, a code-class result issues none, and each read is followed by the write two cycles later. The code values themselves can only be shown by the bench scenarios, which compare against an independent parity model. These scenarios cover the erased-chunk identity, the class boundaries (first and last in-range byte, index past the chunk, one-bit and two-bit differences) and the repaired buffer contents.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  localparam int RAW_W      = 32;
  localparam int RAW_HI_LSB = 16;
  localparam int BYTE_W     = 8;

  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_CODE  = 2'd2,
    CLS_BAD   = 2'd3
  } chk_class_e;

  typedef enum logic [1:0] {
    FX_IDLE = 2'd0,
    FX_READ = 2'd1,
    FX_WAIT = 2'd2
  } fix_state_e;
endpackage

// File: rtl/hecc_accum.sv
module hecc_accum
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int IDX_W       = 9,
  localparam int POS_W      = IDX_W + 3,
  localparam int CODE_W     = 2 * POS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              done,
  output logic              last_take,
  output logic [CODE_W-1:0] code
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_BYTES - 1);

  logic [RAW_W-1:0] raw_q, raw_d;
  logic [IDX_W-1:0] cnt_q;
  logic             done_q;
  logic             take;
  logic [POS_W-1:0] pos;

  assign take      = in_valid && !done_q;
  assign last_take = take && (cnt_q == LAST_IDX);

  // fold the position of every set bit of this byte into both halves
  always_comb begin
    raw_d = raw_q;
    pos   = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      pos = {cnt_q, 3'(b)};
      if (in_data[b]) begin
        raw_d[RAW_HI_LSB +: POS_W] = raw_d[RAW_HI_LSB +: POS_W] ^ pos;
        raw_d[0 +: POS_W]          = raw_d[0 +: POS_W] ^ ~pos;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      raw_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (take) begin
      raw_q <= raw_d;
      if (cnt_q == LAST_IDX) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign in_ready = !done_q;
  assign done     = done_q;
  assign code     = ~{raw_q[RAW_HI_LSB +: POS_W], raw_q[0 +: POS_W]};
endmodule

// File: rtl/hecc_serial.sv
module hecc_serial
  import hecc_pkg::*;
#(
  parameter int CODE_W  = 24,
  localparam int NBYTES = (CODE_W + BYTE_W - 1) / BYTE_W,
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              kick,
  input  logic [CODE_W-1:0] code,
  output logic              bvalid,
  output logic [BYTE_W-1:0] bdata
);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(NBYTES - 1);

  logic                     run_q;
  logic [CNT_W-1:0]         idx_q;
  logic [NBYTES*BYTE_W-1:0] padded;

  assign padded = {{(NBYTES*BYTE_W-CODE_W){1'b1}}, code};

  always_ff @(posedge clk) begin
    if (rst || start) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      bvalid <= 1'b0;
      bdata  <= '0;
    end else if (kick) begin
      run_q  <= 1'b1;
      idx_q  <= '0;
      bvalid <= 1'b0;
    end else if (run_q) begin
      bvalid <= 1'b1;
      bdata  <= padded[idx_q*BYTE_W +: BYTE_W];
      if (idx_q == LAST_B) begin
        run_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else begin
      bvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/hecc_classify.sv
module hecc_classify
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int IDX_W       = 9,
  localparam int POS_W      = IDX_W + 3,
  localparam int CODE_W     = 2 * POS_W
) (
  input  logic [CODE_W-1:0] stored,
  input  logic [CODE_W-1:0] calc,
  output chk_class_e        cls,
  output logic [IDX_W-1:0]  err_byte,
  output logic [2:0]        err_bit
);
  logic [CODE_W-1:0] diff;
  logic [POS_W-1:0]  hi, lo;
  logic              mirrored, in_range;

  assign diff     = stored ^ calc;
  assign hi       = diff[CODE_W-1:POS_W];
  assign lo       = diff[POS_W-1:0];
  assign mirrored = &(hi ^ lo);
  assign in_range = (32'(hi[POS_W-1:3]) < 32'(CHUNK_BYTES));

  always_comb begin
    cls      = CLS_BAD;
    err_byte = '0;
    err_bit  = '0;
    if (diff == '0) begin
      cls = CLS_CLEAN;
    end else if (mirrored) begin
      if (in_range) begin
        cls      = CLS_DATA;
        err_byte = hi[POS_W-1:3];
        err_bit  = hi[2:0];
      end
    end else if ($onehot(diff)) begin
      cls = CLS_CODE;
    end
  end
endmodule

// File: rtl/hecc_fix.sv
module hecc_fix
  import hecc_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [IDX_W-1:0]  go_byte,
  input  logic [2:0]        go_bit,
  output logic              idle,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  fix_state_e state_q;
  logic [2:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FX_IDLE;
      bit_q   <= '0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      rd_en <= 1'b0;
      wr_en <= 1'b0;
      case (state_q)
        FX_IDLE: if (go) begin
          rd_en   <= 1'b1;
          rd_addr <= go_byte;
          bit_q   <= go_bit;
          state_q <= FX_READ;
        end
        FX_READ: state_q <= FX_WAIT;
        FX_WAIT: begin
          wr_en   <= 1'b1;
          wr_addr <= rd_addr;
          wr_data <= rd_data ^ (BYTE_W'(1) << bit_q);
          state_q <= FX_IDLE;
        end
        default: state_q <= FX_IDLE;
      endcase
    end
  end

  assign idle = (state_q == FX_IDLE);
endmodule

// File: rtl/hecc_chunk_engine.sv
module hecc_chunk_engine
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  parameter int IDX_W       = 9,
  localparam int POS_W      = IDX_W + 3,
  localparam int CODE_W     = 2 * POS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              done,
  output logic [CODE_W-1:0] code_out,
  output logic              code_bvalid,
  output logic [7:0]        code_byte,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic [CODE_W-1:0] chk_stored,
  input  logic [CODE_W-1:0] chk_calc,
  output logic              res_valid,
  output logic [1:0]        res_class,
  output logic [IDX_W-1:0]  res_byte,
  output logic [2:0]        res_bit,
  output logic              buf_rd_en,
  output logic [IDX_W-1:0]  buf_rd_addr,
  input  logic [7:0]        buf_rd_data,
  output logic              buf_wr_en,
  output logic [IDX_W-1:0]  buf_wr_addr,
  output logic [7:0]        buf_wr_data
);
  logic             last_take;
  logic             fire, fix_idle;
  chk_class_e       cls_d;
  logic [IDX_W-1:0] byte_d;
  logic [2:0]       bit_d;

  hecc_accum #(.CHUNK_BYTES(CHUNK_BYTES), .IDX_W(IDX_W)) u_accum (
    .clk(clk), .rst(rst), .start(start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .done(done), .last_take(last_take), .code(code_out)
  );

  hecc_serial #(.CODE_W(CODE_W)) u_serial (
    .clk(clk), .rst(rst), .start(start), .kick(last_take),
    .code(code_out), .bvalid(code_bvalid), .bdata(code_byte)
  );

  hecc_classify #(.CHUNK_BYTES(CHUNK_BYTES), .IDX_W(IDX_W)) u_classify (
    .stored(chk_stored), .calc(chk_calc),
    .cls(cls_d), .err_byte(byte_d), .err_bit(bit_d)
  );

  assign chk_ready = fix_idle;
  assign fire      = chk_valid && fix_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_class <= '0;
      res_byte  <= '0;
      res_bit   <= '0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_class <= cls_d;
        res_byte  <= byte_d;
        res_bit   <= bit_d;
      end
    end
  end

  hecc_fix #(.IDX_W(IDX_W)) u_fix (
    .clk(clk), .rst(rst),
    .go(fire && (cls_d == CLS_DATA)), .go_byte(byte_d), .go_bit(bit_d),
    .idle(fix_idle),
    .rd_en(buf_rd_en), .rd_addr(buf_rd_addr), .rd_data(buf_rd_data),
    .wr_en(buf_wr_en), .wr_addr(buf_wr_addr), .wr_data(buf_wr_data)
  );
endmodule

// File: rtl/hecc_chunk_engine_chk.sv
module hecc_chunk_engine_chk #(
  parameter int IDX_W  = 9,
  parameter int CODE_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              in_ready,
  input logic              done,
  input logic [CODE_W-1:0] code_out,
  input logic              code_bvalid,
  input logic              chk_valid,
  input logic              chk_ready,
  input logic              res_valid,
  input logic [1:0]        res_class,
  input logic [IDX_W-1:0]  res_byte,
  input logic [2:0]        res_bit,
  input logic              buf_rd_en,
  input logic [IDX_W-1:0]  buf_rd_addr,
  input logic              buf_wr_en,
  input logic [IDX_W-1:0]  buf_wr_addr
);
  AST_READY_LOW_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready); // R3

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && (&code_out))); // R4

  AST_BYTES_FOLLOW_DONE: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !start) |=> code_bvalid); // R5

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_ready) |=> res_valid); // R6

  AST_CLEAN_NO_INDEX: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 2'd0) |-> (res_byte == '0 && res_bit == '0)); // R6

  AST_CODE_ERR_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 2'd2) |-> !buf_rd_en); // R9

  AST_DATA_ERR_READS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_class == 2'd1) |-> (buf_rd_en && buf_rd_addr == res_byte)); // R11

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    buf_rd_en |=> ##1 (buf_wr_en && buf_wr_addr == $past(buf_rd_addr, 2))); // R11

  AST_BUSY_DURING_FIX: assert property (@(posedge clk) disable iff (rst)
    buf_rd_en |-> !chk_ready); // R11
endmodule

bind hecc_chunk_engine hecc_chunk_engine_chk #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .in_ready(in_ready), .done(done),
  .code_out(code_out), .code_bvalid(code_bvalid), .chk_valid(chk_valid),
  .chk_ready(chk_ready), .res_valid(res_valid), .res_class(res_class),
  .res_byte(res_byte), .res_bit(res_bit), .buf_rd_en(buf_rd_en),
  .buf_rd_addr(buf_rd_addr), .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr)
);

// File: tb/hecc_chunk_engine_tb.sv
`timescale 1ns/1ps
module hecc_chunk_engine_tb;
  localparam int CHUNK = 384;
  localparam int IW    = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, done, code_bvalid;
  logic [23:0] code_out;
  logic [7:0]  code_byte;
  logic        chk_valid = 1'b0;
  logic        chk_ready;
  logic [23:0] chk_stored = '0, chk_calc = '0;
  logic        res_valid;
  logic [1:0]  res_class;
  logic [8:0]  res_byte, buf_rd_addr, buf_wr_addr;
  logic [2:0]  res_bit;
  logic        buf_rd_en, buf_wr_en;
  logic [7:0]  buf_rd_data = '0, buf_wr_data;

  int n_checks = 0;
  int n_errors = 0;
  int n_writes = 0;
  logic [7:0]  src [0:511];
  logic [7:0]  mem [0:511];
  logic [7:0]  code_q [$];
  logic [13:0] res_q [$];

  always #4 clk = ~clk;

  hecc_chunk_engine #(.CHUNK_BYTES(CHUNK), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .done(done), .code_out(code_out),
    .code_bvalid(code_bvalid), .code_byte(code_byte),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_stored(chk_stored),
    .chk_calc(chk_calc), .res_valid(res_valid), .res_class(res_class),
    .res_byte(res_byte), .res_bit(res_bit),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data)
  );

  // buffer model with one cycle read latency
  always @(posedge clk) begin
    if (buf_wr_en) begin
      mem[buf_wr_addr] <= buf_wr_data;
      n_writes <= n_writes + 1;
    end
    if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitors: pop expected items as the design produces them
  always @(negedge clk) begin
    if (!rst && code_bvalid) begin
      if (code_q.size() == 0) check(1'b0, "R5", "unexpected code byte", 32'(code_byte), 0);
      else begin
        logic [7:0] e;
        e = code_q.pop_front();
        check(code_byte == e, "R5", "serial code byte", 32'(code_byte), 32'(e));
      end
    end
    if (!rst && res_valid) begin
      if (res_q.size() == 0) check(1'b0, "R6", "unexpected result", 32'(res_class), 0);
      else begin
        logic [13:0] e;
        e = res_q.pop_front();
        check({res_class, res_byte, res_bit} == e, "R7", "class/byte/bit",
              32'({res_class, res_byte, res_bit}), 32'(e));
      end
    end
  end

  function automatic logic [23:0] model_code(int n);
    logic [11:0] hi = '0, lo = '0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (src[i][b]) begin
          hi ^= 12'(i * 8 + b);
          lo ^= ~12'(i * 8 + b);
        end
    return ~{hi, lo};
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic feed(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = src[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_chunk(string req, output logic [23:0] got);
    logic [23:0] e;
    e = model_code(CHUNK);
    code_q.push_back(e[7:0]);
    code_q.push_back(e[15:8]);
    code_q.push_back(e[23:16]);
    pulse_start();
    feed(CHUNK);
    check(done == 1'b1, "R3", "done after last byte", 32'(done), 1);
    check(in_ready == 1'b0, "R3", "ready low when done", 32'(in_ready), 0);
    check(code_out == e, req, "chunk code", 32'(code_out), 32'(e));
    got = code_out;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_check(input logic [23:0] st, input logic [23:0] ca,
                          input logic [1:0] cls, input logic [8:0] by, input logic [2:0] bi);
    @(negedge clk);
    while (!chk_ready) @(negedge clk);
    res_q.push_back({cls, by, bi});
    chk_valid = 1'b1; chk_stored = st; chk_calc = ca;
    @(negedge clk);
    chk_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [23:0] good, bad, erased;
    logic [11:0] p1, p2, pq;
    int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    check(in_ready && !done && !code_bvalid && !res_valid && !buf_rd_en && !buf_wr_en,
          "R12", "reset outputs", 32'({in_ready, done, code_bvalid, res_valid}), 32'h8);

    // R2: erased chunk
    for (int i = 0; i < 512; i++) src[i] = 8'hFF;
    run_chunk("R2", erased);
    check(erased == 24'hFFFFFF, "R2", "erased code all ones", 32'(erased), 32'hFFFFFF);
    do_check(24'hFFFFFF, erased, 2'd0, 9'd0, 3'd0);

    // R1: patterned chunk
    for (int i = 0; i < 512; i++) src[i] = 8'(i * 37 + 11) ^ 8'(i >> 3);
    for (int i = 0; i < 512; i++) mem[i] = src[i];
    run_chunk("R1", good);

    // R3: byte offered while done is ignored
    @(negedge clk); in_valid = 1'b1; in_data = 8'h5A;
    @(negedge clk); in_valid = 1'b0;
    check(code_out == good && in_ready == 1'b0, "R3", "byte ignored after done",
          32'(code_out), 32'(good));

    // R6: clean
    do_check(good, good, 2'd0, 9'd0, 3'd0);

    // R7 and R11: real single bit error at byte 300 bit 5, repaired in buffer
    src[300] = src[300] ^ 8'h20;
    mem[300] = src[300];
    run_chunk("R1", bad);
    do_check(good, bad, 2'd1, 9'd300, 3'd5);
    check(mem[300] == (src[300] ^ 8'h20), "R11", "byte 300 repaired",
          32'(mem[300]), 32'(src[300] ^ 8'h20));
    src[300] = src[300] ^ 8'h20;

    // R7 boundary: last in-range byte, bit 7
    pq = {9'(CHUNK - 1), 3'd7};
    w0 = n_writes;
    do_check(good, good ^ {pq, ~pq}, 2'd1, 9'(CHUNK - 1), 3'd7);
    check(mem[CHUNK-1] == (src[CHUNK-1] ^ 8'h80), "R11", "last byte bit 7 flipped",
          32'(mem[CHUNK-1]), 32'(src[CHUNK-1] ^ 8'h80));
    check(n_writes == w0 + 1, "R11", "one write per repair", 32'(n_writes), 32'(w0 + 1));

    // R7 first byte bit 0
    pq = 12'd0;
    do_check(good, good ^ {pq, ~pq}, 2'd1, 9'd0, 3'd0);
    check(mem[0] == (src[0] ^ 8'h01), "R11", "byte 0 bit 0 flipped",
          32'(mem[0]), 32'(src[0] ^ 8'h01));

    // R8: mirrored difference beyond the chunk
    pq = {9'd400, 3'd2};
    w0 = n_writes;
    do_check(good, good ^ {pq, ~pq}, 2'd3, 9'd0, 3'd0);
    check(n_writes == w0, "R8", "no write for out of range", 32'(n_writes), 32'(w0));

    // R9: single bit error in the stored code
    do_check(good ^ 24'h000400, good, 2'd2, 9'd0, 3'd0);
    check(n_writes == w0 && mem[10] == src[10], "R9", "code error leaves buffer",
          32'(n_writes), 32'(w0));

    // R10: two data bit errors
    p1 = {9'd10, 3'd1};
    p2 = {9'd20, 3'd6};
    do_check(good, good ^ {p1 ^ p2, p1 ^ p2}, 2'd3, 9'd0, 3'd0);
    check(n_writes == w0 && mem[10] == src[10] && mem[20] == src[20], "R10",
          "double error leaves buffer", 32'(n_writes), 32'(w0));

    // R4: start mid chunk clears everything
    pulse_start();
    feed(10);
    check(done == 1'b0 && code_out == model_code(10), "R4", "partial code",
          32'(code_out), 32'(model_code(10)));
    pulse_start();
    check(code_out == 24'hFFFFFF && done == 1'b0, "R4", "start clears code",
          32'(code_out), 32'hFFFFFF);
    for (int i = 0; i < 512; i++) src[i] = 8'(i ^ 8'hC3) + 8'(i >> 2);
    run_chunk("R1", good);

    repeat (4) @(negedge clk);
    check(code_q.size() == 0, "R5", "all code bytes seen", 32'(code_q.size()), 0);
    check(res_q.size() == 0, "R6", "all results seen", 32'(res_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule